// File: doc/BRIEF.md
# String Operation Address Stepper

This block produces the operand addresses for one element of a string primitive (load, store, move, scan or compare) and advances the implicit index registers after that element. It keeps the source index (SI) and the destination index (DI) in registers. A load strobe writes both from the surrounding logic. A step strobe advances each index the current operation uses, by the element size, in the direction the direction flag selects.

On every cycle the source and destination addresses are formed in real-mode style. The segment value is shifted left by four and the low 16 bits of the index are added to it, giving a 20-bit linear address that wraps at 1 MB. Two flags report which operands the current operation actually touches. The effective address size picks how far the index arithmetic reaches. It is 16 bits or 32 bits, taken from the code-segment default-size bit and inverted by an address-size override flag.

Top module: `strop_addr_step`

## Requirements
- R1: A synchronous reset clears both index registers to zero, and no step or load in that cycle changes this.
- R2: When `load_i` is high, the next clock edge writes `si_i` into SI and `di_i` into DI. If `step_i` is also high in that cycle, the load wins and the step has no effect.
- R3: Operation codes on `op_i`: 0 = load (source only), 1 = store (destination only), 2 = move (both), 3 = scan (destination only), 4 = compare (both). Codes 5 to 7 mark no operand active, and a step with them leaves both indices unchanged.
- R4: Size codes on `size_i`: 0 = byte (step 1), 1 = word (step 2), 2 = doubleword (step 4). Code 3 marks no operand active, and a step with it leaves both indices unchanged.
- R5: With `dir_i` = 0 a step adds the step size to each index it touches. With `dir_i` = 1 it subtracts the step size.
- R6: A step changes SI only when the source is active and DI only when the destination is active. Without a step or load, both indices hold their values.
- R7: The address size is 32 bits when `cs_def_i` XOR `asz_ovr_i` is 1. In that case a stepped index updates as a full 32-bit value modulo 2^32.
- R8: With a 16-bit address size, only the low 16 bits of a stepped index change, modulo 2^16, and the upper 16 bits keep their value.
- R9: `src_addr_o` = (`src_seg_i` << 4) + SI[15:0] and `dst_addr_o` = (`dst_seg_i` << 4) + DI[15:0], each modulo 2^20. Both are formed from the current index registers on every cycle, whatever the operand activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Write `si_i` and `di_i` into the index registers |
| si_i | input | 32 | Source index value to load |
| di_i | input | 32 | Destination index value to load |
| step_i | input | 1 | Advance the indices for one element |
| op_i | input | 3 | String operation code |
| size_i | input | 2 | Element size code |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| cs_def_i | input | 1 | Code-segment default size: 0 = 16-bit, 1 = 32-bit |
| asz_ovr_i | input | 1 | Address-size override present (inverts the default) |
| src_seg_i | input | 16 | Source segment value |
| dst_seg_i | input | 16 | Destination segment value |
| src_addr_o | output | 20 | Source linear address |
| dst_addr_o | output | 20 | Destination linear address |
| src_act_o | output | 1 | Current operation reads the source operand |
| dst_act_o | output | 1 | Current operation uses the destination operand |
| si_o | output | 32 | Current SI register |
| di_o | output | 32 | Current DI register |

## Verification
Two things can land on the same clock edge: a load of new index values and a step of the old ones. Move and compare also advance SI and DI together on one edge. The bench raises `load_i` and `step_i` in the same cycle and expects exactly the loaded values afterwards, with no increment applied. It then steps move and compare, with both indices placed at the 0x0000 and 0xFFFF boundaries, and compares each register and both addresses against a model built from the requirements.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_MOVE  = 3'd2,
        OP_SCAN  = 3'd3,
        OP_CMP   = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } elem_sz_e;

    localparam int unsigned MAG_W = 3;

    typedef struct packed {
        logic             use_src;
        logic             use_dst;
        logic [MAG_W-1:0] mag;
    } step_ctl_t;

endpackage

// File: rtl/strop_decode.sv
module strop_decode
    import strop_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic [1:0] size_i,
    output step_ctl_t  ctl_o
);
    logic src_raw, dst_raw, size_ok;
    logic [MAG_W-1:0] mag_raw;

    always_comb begin
        src_raw = 1'b0;
        dst_raw = 1'b0;
        case (str_op_e'(op_i))
            OP_LOAD:  src_raw = 1'b1;
            OP_STORE: dst_raw = 1'b1;
            OP_MOVE:  begin src_raw = 1'b1; dst_raw = 1'b1; end
            OP_SCAN:  dst_raw = 1'b1;
            OP_CMP:   begin src_raw = 1'b1; dst_raw = 1'b1; end
            default:  ;
        endcase
    end

    always_comb begin
        size_ok = 1'b1;
        mag_raw = '0;
        case (elem_sz_e'(size_i))
            SZ_BYTE:  mag_raw = MAG_W'(1);
            SZ_WORD:  mag_raw = MAG_W'(2);
            SZ_DWORD: mag_raw = MAG_W'(4);
            default:  size_ok = 1'b0;
        endcase
    end

    assign ctl_o.use_src = src_raw & size_ok;
    assign ctl_o.use_dst = dst_raw & size_ok;
    assign ctl_o.mag     = mag_raw;
endmodule

// File: rtl/strop_idx_adv.sv
module strop_idx_adv #(
    parameter int unsigned IDX_W    = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned MAG_W    = 3
) (
    input  logic [IDX_W-1:0] cur_i,
    input  logic             en_i,
    input  logic             dec_i,
    input  logic             wide_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [IDX_W-1:0] nxt_o
);
    logic [IDX_W-1:0]    full_sum;
    logic [NARROW_W-1:0] low_sum;
    logic [IDX_W-1:0]    narrow_val;

    always_comb begin
        full_sum = dec_i ? (cur_i - IDX_W'(mag_i)) : (cur_i + IDX_W'(mag_i));
        low_sum  = dec_i ? (cur_i[NARROW_W-1:0] - NARROW_W'(mag_i))
                         : (cur_i[NARROW_W-1:0] + NARROW_W'(mag_i));
    end

    generate
        if (IDX_W > NARROW_W) begin : g_keep_upper
            assign narrow_val = {cur_i[IDX_W-1:NARROW_W], low_sum};
        end else begin : g_flat
            assign narrow_val = low_sum;
        end
    endgenerate

    assign nxt_o = !en_i ? cur_i : (wide_i ? full_sum : narrow_val);
endmodule

// File: rtl/strop_lin_addr.sv
module strop_lin_addr #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned LIN_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [LIN_W-1:0] lin_o
);
    assign lin_o = {seg_i, {SHIFT{1'b0}}} + LIN_W'(off_i);
endmodule

// File: rtl/strop_addr_step.sv
module strop_addr_step
    import strop_pkg::*;
#(
    parameter int unsigned IDX_W = 32,
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned LIN_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [IDX_W-1:0] si_i,
    input  logic [IDX_W-1:0] di_i,
    input  logic             step_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       size_i,
    input  logic             dir_i,
    input  logic             cs_def_i,
    input  logic             asz_ovr_i,
    input  logic [SEG_W-1:0] src_seg_i,
    input  logic [SEG_W-1:0] dst_seg_i,
    output logic [LIN_W-1:0] src_addr_o,
    output logic [LIN_W-1:0] dst_addr_o,
    output logic             src_act_o,
    output logic             dst_act_o,
    output logic [IDX_W-1:0] si_o,
    output logic [IDX_W-1:0] di_o
);
    typedef struct packed {
        logic [IDX_W-1:0] si;
        logic [IDX_W-1:0] di;
    } idx_regs_t;

    idx_regs_t regs_d, regs_q;
    step_ctl_t ctl;
    logic      wide;
    logic [IDX_W-1:0] si_adv, di_adv;

    strop_decode u_dec (
        .op_i   (op_i),
        .size_i (size_i),
        .ctl_o  (ctl)
    );

    assign wide = cs_def_i ^ asz_ovr_i;

    strop_idx_adv #(.IDX_W(IDX_W), .NARROW_W(OFF_W), .MAG_W(MAG_W)) u_si_adv (
        .cur_i  (regs_q.si),
        .en_i   (ctl.use_src),
        .dec_i  (dir_i),
        .wide_i (wide),
        .mag_i  (ctl.mag),
        .nxt_o  (si_adv)
    );

    strop_idx_adv #(.IDX_W(IDX_W), .NARROW_W(OFF_W), .MAG_W(MAG_W)) u_di_adv (
        .cur_i  (regs_q.di),
        .en_i   (ctl.use_dst),
        .dec_i  (dir_i),
        .wide_i (wide),
        .mag_i  (ctl.mag),
        .nxt_o  (di_adv)
    );

    strop_lin_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_src_lin (
        .seg_i (src_seg_i),
        .off_i (regs_q.si[OFF_W-1:0]),
        .lin_o (src_addr_o)
    );

    strop_lin_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_dst_lin (
        .seg_i (dst_seg_i),
        .off_i (regs_q.di[OFF_W-1:0]),
        .lin_o (dst_addr_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (load_i) begin
            regs_d.si = si_i;
            regs_d.di = di_i;
        end else if (step_i) begin
            regs_d.si = si_adv;
            regs_d.di = di_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign src_act_o = ctl.use_src;
    assign dst_act_o = ctl.use_dst;
    assign si_o      = regs_q.si;
    assign di_o      = regs_q.di;
endmodule

// File: rtl/strop_addr_step_chk.sv
module strop_addr_step_chk #(
    parameter int unsigned IDX_W = 32,
    parameter int unsigned LIN_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [IDX_W-1:0] si_i,
    input logic             step_i,
    input logic [2:0]       op_i,
    input logic             cs_def_i,
    input logic             asz_ovr_i,
    input logic [LIN_W-1:0] src_addr_o,
    input logic             src_act_o,
    input logic             dst_act_o,
    input logic [IDX_W-1:0] si_o,
    input logic [IDX_W-1:0] di_o
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (si_o == '0 && di_o == '0));

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(load_i) && !$past(rst)) |-> (si_o == $past(si_i)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_i) && !$past(step_i)) |-> ($stable(si_o) && $stable(di_o)));

    // R3
    store_keeps_si_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_i) && $past(step_i) && ($past(op_i) == 3'd1 || $past(op_i) == 3'd3))
        |-> $stable(si_o));

    // R3
    bad_op_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i > 3'd4) |-> (!src_act_o && !dst_act_o));

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_i) && $past(step_i) && !($past(cs_def_i) ^ $past(asz_ovr_i)))
        |-> (si_o[IDX_W-1:16] == $past(si_o[IDX_W-1:16]) && di_o[IDX_W-1:16] == $past(di_o[IDX_W-1:16])));

    // R9
    low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        src_addr_o[3:0] == si_o[3:0]);
endmodule

bind strop_addr_step strop_addr_step_chk #(.IDX_W(IDX_W), .LIN_W(LIN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .si_i       (si_i),
    .step_i     (step_i),
    .op_i       (op_i),
    .cs_def_i   (cs_def_i),
    .asz_ovr_i  (asz_ovr_i),
    .src_addr_o (src_addr_o),
    .src_act_o  (src_act_o),
    .dst_act_o  (dst_act_o),
    .si_o       (si_o),
    .di_o       (di_o)
);

// File: tb/sim_strop_addr_step.sv
module sim_strop_addr_step;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_i, step_i, dir_i, cs_def_i, asz_ovr_i;
    logic [31:0] si_i, di_i;
    logic [2:0]  op_i;
    logic [1:0]  size_i;
    logic [15:0] src_seg_i, dst_seg_i;
    logic [19:0] src_addr_o, dst_addr_o;
    logic        src_act_o, dst_act_o;
    logic [31:0] si_o, di_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    strop_addr_step u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .si_i(si_i), .di_i(di_i),
        .step_i(step_i), .op_i(op_i), .size_i(size_i), .dir_i(dir_i),
        .cs_def_i(cs_def_i), .asz_ovr_i(asz_ovr_i),
        .src_seg_i(src_seg_i), .dst_seg_i(dst_seg_i),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
        .src_act_o(src_act_o), .dst_act_o(dst_act_o),
        .si_o(si_o), .di_o(di_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic        dir;
        logic        csd;
        logic        ovr;
        logic [31:0] si;
        logic [31:0] di;
        logic [15:0] ds;
        logic [15:0] es;
        logic [31:0] e_si;
        logic [31:0] e_di;
        logic [19:0] e_sa;
        logic [19:0] e_da;
        logic        e_sact;
        logic        e_dact;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1234, 32'h0000_5678, 16'h1000, 16'h2000,
          32'h0000_1235, 32'h0000_5678, 20'h11234, 20'h25678, 1'b1, 1'b0},
        '{3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0010, 32'hABCD_0001, 16'h0000, 16'hF000,
          32'h0000_0010, 32'hABCD_FFFF, 20'h00010, 20'hF0001, 1'b0, 1'b1},
        '{3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_FFFE, 32'hFFFF_FFFC, 16'hFFFF, 16'h0000,
          32'h0001_0002, 32'h0000_0000, 20'h0FFEE, 20'h0FFFC, 1'b1, 1'b1},
        '{3'd2, 2'd2, 1'b0, 1'b1, 1'b1, 32'h1234_FFFE, 32'h0000_FFFC, 16'h1234, 16'h0001,
          32'h1234_0002, 32'h0000_0000, 20'h2233E, 20'h1000C, 1'b1, 1'b1},
        '{3'd3, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_0005, 32'h0001_0000, 16'h0000, 16'h0800,
          32'h0000_0005, 32'h0000_FFFF, 20'h00005, 20'h08000, 1'b0, 1'b1},
        '{3'd4, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0100, 16'hFFFF, 16'h0010,
          32'h0000_FFFE, 32'h0000_00FE, 20'hFFFF0, 20'h00200, 1'b1, 1'b1},
        '{3'd0, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_0002, 32'h0000_0007, 16'h0001, 16'h0000,
          32'hFFFF_FFFE, 32'h0000_0007, 20'h00012, 20'h00007, 1'b1, 1'b0},
        '{3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0200, 16'h0000, 16'h0000,
          32'h0000_0100, 32'h0000_0200, 20'h00100, 20'h00200, 1'b0, 1'b0},
        '{3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0400, 16'h0000, 16'h0000,
          32'h0000_0300, 32'h0000_0400, 20'h00300, 20'h00400, 1'b0, 1'b0},
        '{3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_FFFF, 16'h0000, 16'h0000,
          32'h0000_0001, 32'h0000_0000, 20'h00001, 20'h0FFFF, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        load_i = 1'b1; si_i = s; di_i = d;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_step();
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    function automatic logic [31:0] model_idx(input logic [31:0] v, input logic act,
                                              input logic [1:0] sz, input logic dir, input logic wide);
        logic [31:0] m;
        logic [31:0] r;
        m = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        if (!act) return v;
        r = dir ? v - m : v + m;
        if (!wide) r = {v[31:16], r[15:0]};
        return r;
    endfunction

    initial begin
        logic [31:0] sv, dv;
        logic ea_s, ea_d;
        rst = 1'b1; load_i = 1'b0; step_i = 1'b0; si_i = '0; di_i = '0;
        op_i = '0; size_i = '0; dir_i = 1'b0; cs_def_i = 1'b0; asz_ovr_i = 1'b0;
        src_seg_i = '0; dst_seg_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "si after reset", si_o, 32'h0);
        chk("R1", "di after reset", di_o, 32'h0);
        rst = 1'b0;

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].si, VECS[i].di);
            op_i = VECS[i].op; size_i = VECS[i].sz; dir_i = VECS[i].dir;
            cs_def_i = VECS[i].csd; asz_ovr_i = VECS[i].ovr;
            src_seg_i = VECS[i].ds; dst_seg_i = VECS[i].es;
            #1;
            chk("R9", "src_addr", {12'h0, src_addr_o}, {12'h0, VECS[i].e_sa});
            chk("R9", "dst_addr", {12'h0, dst_addr_o}, {12'h0, VECS[i].e_da});
            chk("R3", "src_act", {31'h0, src_act_o}, {31'h0, VECS[i].e_sact});
            chk("R3", "dst_act", {31'h0, dst_act_o}, {31'h0, VECS[i].e_dact});
            do_step();
            chk("R6", "si after step", si_o, VECS[i].e_si);
            chk("R8", "di after step", di_o, VECS[i].e_di);
        end

        // exhaustive combinations near both 16-bit boundaries: R4 R5 R7 R8
        for (int op = 0; op < 5; op++)
            for (int sz = 0; sz < 3; sz++)
                for (int c = 0; c < 8; c++) begin
                    sv = 32'h1234_FFFF;
                    dv = 32'hFFFF_0000;
                    do_load(sv, dv);
                    op_i = 3'(op); size_i = 2'(sz);
                    dir_i = c[0]; cs_def_i = c[1]; asz_ovr_i = c[2];
                    src_seg_i = 16'hFFFF; dst_seg_i = 16'hF001;
                    ea_s = (op == 0) || (op == 2) || (op == 4);
                    ea_d = (op != 0);
                    #1;
                    chk("R9", "src_addr wrap", {12'h0, src_addr_o}, 32'h0000_FFEF);
                    chk("R9", "dst_addr", {12'h0, dst_addr_o}, 32'h000F_0010);
                    do_step();
                    chk("R7", "si combo", si_o, model_idx(sv, ea_s, 2'(sz), c[0], c[1] ^ c[2]));
                    chk("R5", "di combo", di_o, model_idx(dv, ea_d, 2'(sz), c[0], c[1] ^ c[2]));
                end

        // R2: load and step in the same cycle, load wins
        op_i = 3'd2; size_i = 2'd2; dir_i = 1'b0; cs_def_i = 1'b1; asz_ovr_i = 1'b0;
        @(negedge clk);
        load_i = 1'b1; step_i = 1'b1; si_i = 32'h0000_4000; di_i = 32'h0000_8000;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
        chk("R2", "si load wins", si_o, 32'h0000_4000);
        chk("R2", "di load wins", di_o, 32'h0000_8000);

        // R6: no strobe, indices hold
        repeat (3) @(negedge clk);
        chk("R6", "si hold", si_o, 32'h0000_4000);
        chk("R6", "di hold", di_o, 32'h0000_8000);

        // R1: reset with a step pending clears
        rst = 1'b1; step_i = 1'b1;
        @(negedge clk);
        rst = 1'b0; step_i = 1'b0;
        chk("R1", "si reset mid-run", si_o, 32'h0);
        chk("R1", "di reset mid-run", di_o, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule